// File: doc/BRIEF.md
# Dual-Mode Serial Result Transmitter

This block sends a converter's 16-bit result word out on one serial data line. It runs in one of two modes. In the self-clocked mode, a conversion start also sends the word the converter presents at that moment, which is the result of the previous conversion. The block makes exactly as many data-clock pulses as the word has bits, from a divided system clock. In the host-clocked mode, the host drives the data clock. The block then gives a one-pulse framing mark, shifts the word out, and after the word passes a tag input through, delayed by one word length. Several transmitters can then be chained.

The output coding can be chosen. The word arrives in offset (straight) binary and may be sent unchanged or as two's complement. All asynchronous control inputs (chip select, read/convert, host clock, tag) pass through a synchronizer before the edge detectors that use them. Everything runs on the system clock with a synchronous active-high reset.

Top module: `sertx_result_tx`

## Requirements
- R1: While reset is asserted, and right after it is released, `sdata_o`, `dclk_o` and `sync_o` are all low.
- R2: In self-clocked mode (`ext_mode_i`=0), a falling edge of (`sel_n_i` OR `rdconv_i`) captures `word_i` and sends it MSB first with exactly WIDTH pulses on `dclk_o`. Each bit changes just after a falling edge of `dclk_o` and is stable at the next rising edge. Later changes of `word_i` do not affect the transfer.
- R3: The generated `dclk_o` has a period of 2*DIV_HALF system clocks, with equal high and low halves. It stays low after the last pulse.
- R4: In self-clocked mode, after the last bit `sdata_o` holds the `tag_i` level captured at the conversion start. It keeps that level until the next transfer, even if `tag_i` changes.
- R5: With `straight_i`=1 the word is sent as-is. With `straight_i`=0 its MSB is inverted (two's complement), so 0x8000 is sent as 0x0000 and 0xFFFF as 0x7FFF.
- R6: In host-clocked mode (`ext_mode_i`=1), a rising edge of `rdconv_i` while `sel_n_i` is low opens a read session and captures the coded word.
- R7: In host-clocked mode, a falling edge of `sel_n_i` while `rdconv_i` is high also opens a read session.
- R8: In a session, `sync_o` rises after the first rising edge of `xclk_i` and falls after the following falling edge. The MSB then appears, the next bits follow after each later falling edge, and the host reads bit k at rising edge k+1 after the sync rise.
- R9: After the word, `sdata_o` read at rising edge p carries the `tag_i` level sampled at rising edge p-16, for as long as `sel_n_i` is low and `rdconv_i` is high.
- R10: Raising `sel_n_i` or lowering `rdconv_i` ends the session. Further `xclk_i` edges then leave `sdata_o` unchanged and `sync_o` low.
- R11: In self-clocked mode, a conversion start during a running transfer is ignored. The running transfer still delivers exactly WIDTH pulses with the original word.
- R12: In host-clocked mode, a conversion start produces no `dclk_o` pulses. In self-clocked mode, `sync_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | WIDTH | Result word, straight binary |
| ext_mode_i | input | 1 | 1 = host-clocked mode, 0 = self-clocked mode |
| straight_i | input | 1 | 1 = straight binary, 0 = two's complement |
| sel_n_i | input | 1 | Chip select, active low (asynchronous) |
| rdconv_i | input | 1 | Read/convert control (asynchronous) |
| xclk_i | input | 1 | Host data clock (asynchronous) |
| tag_i | input | 1 | Tag level for chaining (asynchronous) |
| sdata_o | output | 1 | Serial data |
| dclk_o | output | 1 | Generated data clock (self-clocked mode) |
| sync_o | output | 1 | Session framing pulse (host-clocked mode) |

## Verification
The embedded properties check, on every cycle, several local rules. A generated clock fall always comes just after a high phase. The sync pulse rises only after a detected host-clock rise and falls only for a defined reason. No sync appears in self-clocked mode, and the shift register holds unless it is loaded or shifted. Some behaviour can only be shown by the bench's end-to-end scenarios: the exact pulse count and period, the bit order under both codings, the tag captured in self-clocked mode, and the sixteen-pulse tag delay. So can the two session-opening conditions, the ignored second start and the frozen output after an abort.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  // Bit positions inside the synchronizer vector
  localparam int SI_XCLK = 0;
  localparam int SI_SELN = 1;
  localparam int SI_RC   = 2;
  localparam int SI_TAG  = 3;
  localparam int SI_NUM  = 4;

  // Host-clocked read session states
  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_ARM   = 2'd1,
    XS_SYNC  = 2'd2,
    XS_SHIFT = 2'd3
  } xstate_t;
endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  localparam int TOT = N * STAGES;

  logic [TOT-1:0] chain;

  // Plain flop chain, filled during reset so no false edges follow it
  always_ff @(posedge clk) begin
    chain <= TOT'({chain, d});
  end

  assign q = chain[TOT-1 -: N];
endmodule

// File: rtl/sertx_intclk.sv
module sertx_intclk #(
  parameter int WIDTH    = 16,
  parameter int DIV_HALF = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic dclk,
  output logic fall,
  output logic busy
);
  localparam int HW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [HW-1:0] hc_q;
  logic [CW-1:0] pc_q;
  logic          busy_q;
  logic          phase_q;
  logic          fall_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_q    <= '0;
      pc_q    <= '0;
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          phase_q <= 1'b0;
          hc_q    <= '0;
          pc_q    <= '0;
        end
      end else if (hc_q == HW'(DIV_HALF - 1)) begin
        hc_q <= '0;
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          fall_q  <= 1'b1;
          if (pc_q == CW'(WIDTH - 1)) busy_q <= 1'b0;
          else                        pc_q   <= pc_q + 1'b1;
        end
      end else begin
        hc_q <= hc_q + 1'b1;
      end
    end
  end

  assign dclk = phase_q;
  assign fall = fall_q;
  assign busy = busy_q;

  // R2
  fall_after_high_chk: assert property (@(posedge clk) disable iff (rst)
    fall_q |-> (!phase_q && $past(phase_q)));

  // R3
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !$past(busy_q)) |-> !phase_q);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_word,
  input  logic             shift,
  input  logic             shift_in,
  output logic             msb
);
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)        sr_q <= '0;
    else if (load)  sr_q <= load_word;
    else if (shift) sr_q <= {sr_q[WIDTH-2:0], shift_in};
  end

  assign msb = sr_q[WIDTH-1];

  // R10
  hold_when_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(load) && !$past(shift)) |-> $stable(sr_q));
endmodule

// File: rtl/sertx_result_tx.sv
module sertx_result_tx
  import sertx_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int DIV_HALF    = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] word_i,
  input  logic             ext_mode_i,
  input  logic             straight_i,
  input  logic             sel_n_i,
  input  logic             rdconv_i,
  input  logic             xclk_i,
  input  logic             tag_i,
  output logic             sdata_o,
  output logic             dclk_o,
  output logic             sync_o
);
  // ---------------- input synchronization and edges ----------------
  logic [SI_NUM-1:0] raw, syn, prev_q;

  always_comb begin
    raw          = '0;
    raw[SI_XCLK] = xclk_i;
    raw[SI_SELN] = sel_n_i;
    raw[SI_RC]   = rdconv_i;
    raw[SI_TAG]  = tag_i;
  end

  sertx_sync #(.N(SI_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (raw),
    .q   (syn)
  );

  always_ff @(posedge clk) begin
    prev_q <= syn;
  end

  logic xr, xf, rc_rise, sel_fall, conv_start, session_ok, ext_trig;

  assign xr         = syn[SI_XCLK] & ~prev_q[SI_XCLK];
  assign xf         = ~syn[SI_XCLK] & prev_q[SI_XCLK];
  assign rc_rise    = syn[SI_RC] & ~prev_q[SI_RC];
  assign sel_fall   = ~syn[SI_SELN] & prev_q[SI_SELN];
  assign conv_start = ~(syn[SI_SELN] | syn[SI_RC]) & (prev_q[SI_SELN] | prev_q[SI_RC]);
  assign session_ok = ~syn[SI_SELN] & syn[SI_RC];
  assign ext_trig   = ext_mode_i &
                      ((rc_rise & ~syn[SI_SELN]) | (sel_fall & syn[SI_RC]));

  // ---------------- output coding ----------------
  logic [WIDTH-1:0] coded;
  assign coded = straight_i ? word_i : {~word_i[WIDTH-1], word_i[WIDTH-2:0]};

  // ---------------- self-clocked generator ----------------
  logic int_busy, int_fall, int_start, int_dclk;

  assign int_start = conv_start & ~ext_mode_i & ~int_busy;

  sertx_intclk #(.WIDTH(WIDTH), .DIV_HALF(DIV_HALF)) u_intclk (
    .clk   (clk),
    .rst   (rst),
    .start (int_start),
    .dclk  (int_dclk),
    .fall  (int_fall),
    .busy  (int_busy)
  );

  assign dclk_o = int_dclk;

  // ---------------- host-clocked session ----------------
  xstate_t xs_q;
  logic    sync_q;
  logic    tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xs_q   <= XS_IDLE;
      sync_q <= 1'b0;
    end else if (!ext_mode_i) begin
      xs_q   <= XS_IDLE;
      sync_q <= 1'b0;
    end else if (ext_trig) begin
      xs_q   <= XS_ARM;
      sync_q <= 1'b0;
    end else if (xs_q != XS_IDLE && !session_ok) begin
      xs_q   <= XS_IDLE;
      sync_q <= 1'b0;
    end else begin
      case (xs_q)
        XS_ARM:   if (xr) begin xs_q <= XS_SYNC;  sync_q <= 1'b1; end
        XS_SYNC:  if (xf) begin xs_q <= XS_SHIFT; sync_q <= 1'b0; end
        default:  ;
      endcase
    end
  end

  // Tag: captured at a conversion start (self-clocked) or at each host rise
  always_ff @(posedge clk) begin
    if (rst)                                         tag_q <= 1'b0;
    else if (int_start)                              tag_q <= syn[SI_TAG];
    else if (ext_mode_i && xr && xs_q != XS_IDLE)    tag_q <= syn[SI_TAG];
  end

  assign sync_o = sync_q;

  // ---------------- shared shifter ----------------
  logic sh_load, sh_shift;

  assign sh_load  = int_start | ext_trig;
  assign sh_shift = int_fall |
                    (ext_mode_i & (xs_q == XS_SHIFT) & xf & session_ok);

  sertx_shift #(.WIDTH(WIDTH)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .load_word (coded),
    .shift     (sh_shift),
    .shift_in  (tag_q),
    .msb       (sdata_o)
  );

  // ---------------- assertions ----------------
  // R8
  sync_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $past(xr));

  // R8
  sync_drop_reason_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_o) |-> ($past(xf) || $past(!session_ok) ||
                       $past(!ext_mode_i) || $past(ext_trig)));

  // R12
  no_sync_selfclk_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ext_mode_i) |-> !sync_o);

  // R10
  session_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (ext_mode_i && xs_q != XS_IDLE && !session_ok) |=> (xs_q == XS_IDLE && !sync_o));
endmodule

// File: tb/tb_sertx_result_tx.sv
module tb_sertx_result_tx;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 16;
  localparam int DIVH = 11;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] word_i = '0;
  logic         ext_mode_i = 1'b0, straight_i = 1'b1;
  logic         sel_n_i = 1'b1, rdconv_i = 1'b1, xclk_i = 1'b0, tag_i = 1'b0;
  logic         sdata_o, dclk_o, sync_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sertx_result_tx #(.WIDTH(W), .DIV_HALF(DIVH), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .word_i(word_i), .ext_mode_i(ext_mode_i),
    .straight_i(straight_i), .sel_n_i(sel_n_i), .rdconv_i(rdconv_i),
    .xclk_i(xclk_i), .tag_i(tag_i), .sdata_o(sdata_o), .dclk_o(dclk_o),
    .sync_o(sync_o)
  );

  function automatic logic [W-1:0] code_of(input logic [W-1:0] w, input logic sb);
    return sb ? w : {~w[W-1], w[W-2:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Self-clocked transfer: R2 R3 R4 R5 R11
  task automatic int_xfer(input logic [W-1:0] w, input logic sb, input logic tg, input bit restart);
    logic [W-1:0] exp, got;
    int npulse, last_rise, cyc;
    logic prev_d;
    exp = code_of(w, sb);
    ext_mode_i = 1'b0; straight_i = sb; word_i = w; tag_i = tg;
    sel_n_i = 1'b0; rdconv_i = 1'b1;
    idle(6);
    rdconv_i = 1'b0;
    npulse = 0; last_rise = -1; prev_d = 1'b0; got = '0;
    for (int c = 0; c < 2*DIVH*W + 40; c++) begin
      @(negedge clk);
      cyc = c;
      if (c == 6) begin tag_i = ~tg; word_i = ~w; end
      if (restart && c == 60) rdconv_i = 1'b1;
      if (restart && c == 70) rdconv_i = 1'b0;
      if (dclk_o && !prev_d) begin
        if (npulse < W) got[W-1-npulse] = sdata_o;
        if (last_rise >= 0)
          chk(cyc - last_rise == 2*DIVH, "R3 dclk period", cyc - last_rise, 2*DIVH);
        last_rise = cyc;
        npulse++;
      end
      prev_d = dclk_o;
    end
    chk(npulse == W, restart ? "R11 pulse count with restart" : "R2 pulse count", npulse, W);
    chk(got == exp, sb ? "R2 R5 straight word" : "R5 twos complement word", got, exp);
    chk(dclk_o == 1'b0, "R3 dclk low after transfer", dclk_o, 0);
    chk(sdata_o == tg, "R4 captured tag after word", sdata_o, tg);
    rdconv_i = 1'b1;
    idle(20);
    chk(sdata_o == tg && dclk_o == 1'b0, "R4 tag held between conversions", sdata_o, tg);
  endtask

  // Host-clocked session: R6 R7 R8 R9 R10 R12
  task automatic ext_xfer(input logic [W-1:0] w, input logic sb, input bit by_sel, input int abort_at);
    logic [W-1:0] exp;
    logic tg_arr [0:33];
    logic snap, expb;
    bit aborted;
    exp = code_of(w, sb);
    ext_mode_i = 1'b1; straight_i = sb; word_i = w; xclk_i = 1'b0;
    if (by_sel) begin sel_n_i = 1'b1; rdconv_i = 1'b1; end
    else        begin sel_n_i = 1'b0; rdconv_i = 1'b0; end
    idle(8);
    if (by_sel) sel_n_i = 1'b0; else rdconv_i = 1'b1;
    idle(6);
    word_i = ~w;
    aborted = 1'b0; snap = 1'b0;
    for (int p = 0; p < 34; p++) begin
      tg_arr[p] = 1'($urandom % 2);
      tag_i = tg_arr[p];
      if (p == abort_at) rdconv_i = 1'b0;
      idle(6);
      if (p == abort_at) begin snap = sdata_o; aborted = 1'b1; end
      else if (aborted) begin
        chk(sdata_o == snap, "R10 data frozen after abort", sdata_o, snap);
        chk(dclk_o == 1'b0, "R12 no generated clock in host mode", dclk_o, 0);
      end else if (p >= 1) begin
        expb = (p <= W) ? exp[W-p] : tg_arr[p-W];
        chk(sdata_o == expb,
            (p <= W) ? (by_sel ? "R7 R8 R5 data bit" : "R6 R8 R5 data bit") : "R9 delayed tag",
            sdata_o, expb);
      end
      xclk_i = 1'b1;
      idle(5);
      chk(sync_o == (p == 0 && !aborted), aborted ? "R10 no sync after abort" : "R8 sync pulse",
          sync_o, (p == 0 && !aborted));
      xclk_i = 1'b0;
    end
    sel_n_i = 1'b1; rdconv_i = 1'b1;
    idle(10);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (10) @(negedge clk);
    chk(sdata_o == 0 && dclk_o == 0 && sync_o == 0, "R1 outputs during reset",
        {sdata_o, dclk_o, sync_o}, 0);
    rst = 1'b0;
    idle(3);
    chk(sdata_o == 0 && dclk_o == 0 && sync_o == 0, "R1 outputs after reset",
        {sdata_o, dclk_o, sync_o}, 0);

    // Directed corners
    int_xfer(16'h8000, 1'b1, 1'b1, 1'b0);
    int_xfer(16'h8000, 1'b0, 1'b0, 1'b0);
    int_xfer(16'hFFFF, 1'b0, 1'b1, 1'b0);
    int_xfer(16'h0001, 1'b1, 1'b0, 1'b1);
    chk(sync_o == 1'b0, "R12 no sync in self-clocked mode", sync_o, 0);
    ext_xfer(16'hA5C3, 1'b1, 1'b0, -1);
    ext_xfer(16'h8000, 1'b0, 1'b1, -1);
    ext_xfer(16'h3C5A, 1'b1, 1'b0, 5);

    // Random mix
    for (int i = 0; i < 6; i++) begin
      int_xfer(16'($urandom), 1'($urandom % 2), 1'($urandom % 2), (i % 3) == 0);
      ext_xfer(16'($urandom), 1'($urandom % 2), 1'($urandom % 2),
               (i % 2) ? int'($urandom % 30) + 2 : -1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule